// File: doc/BRIEF.md
# BIP-8 Parity Error Monitor with Period Accounting

This block watches a byte-wide frame stream and checks two bit-interleaved parities. For each parity it XORs the chosen bytes of one frame into an 8-bit value. That value becomes the reference for the parity byte carried in the next frame. The number of bit positions that disagree is that frame's error count. The first parity covers every byte. The second parity covers only the bytes marked by a per-byte enable. A third count comes from outside: the far end reports its own error tally on a small bus.

The three counts are summed over a period that the host sets in frames. When a period closes, the running sums move into holding outputs and the sums restart from zero. The signal-degrade and signal-fail flags are then re-judged from the second-parity total. An interrupt can be raised at that moment.

Top module: `bip_err_monitor`

## Requirements
- R1: After reset all three totals are 0, and `sd_o`, `sf_o` and `irq_o` are low.
- R2: The first parity is the XOR of every valid byte from one frame start (inclusive) to the next. In the following frame, a valid byte with `b1_pos_i` high is compared with it. The error count is the number of set bits in the XOR of the two, from 0 to 8, and is added to the first-parity sum.
- R3: The second parity works as in R2, but only valid bytes with `b2_en_i` high are folded in, and the compare happens at `b2_pos_i`.
- R4: A parity byte is checked only if `sync_ok_i` was high at the frame start of the previous frame, at this frame's start, and in every cycle between. This means the frame opened by the first frame start after reset or after sync loss is never checked.
- R5: Each valid `sof_i` counts one frame. The frame start that completes `period_i` frames closes the period. A `period_i` of 0 or 1 closes a period on every frame start. On that edge each total takes its sum, including any count arriving in the same cycle, and the sum restarts from 0. Totals hold between period ends.
- R6: When `fe_vld_i` is high, `fe_err_i` is added to the far-end sum in that cycle.
- R7: Every sum and total saturates at 2^CNT_W-1.
- R8: At each period end `sd_o` becomes 1 if the new second-parity total exceeds `sd_thresh_i`, else 0. It holds otherwise.
- R9: At each period end `sf_o` becomes 1 if the new second-parity total exceeds `sf_thresh_i`, else 0. It holds otherwise.
- R10: A period end with `irq_en_i` high sets `irq_o`. `irq_o` stays high until a cycle with `irq_clr_i` high, and a set in the same cycle wins over the clear.
- R11: A cycle with `valid_i` low has no effect, whatever the values of `data_i`, `sof_i`, `b1_pos_i`, `b2_pos_i` and `b2_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte valid |
| data_i | input | 8 | Stream byte |
| sof_i | input | 1 | Byte is the first of a frame |
| b1_pos_i | input | 1 | Byte is the first-parity byte |
| b2_pos_i | input | 1 | Byte is the second-parity byte |
| b2_en_i | input | 1 | Byte is covered by the second parity |
| sync_ok_i | input | 1 | Frame alignment present |
| fe_vld_i | input | 1 | Far-end count valid |
| fe_err_i | input | FE_W | Far-end error count |
| period_i | input | PER_W | Period length in frames |
| sd_thresh_i | input | CNT_W | Degrade threshold |
| sf_thresh_i | input | CNT_W | Fail threshold |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Interrupt clear |
| b1_total_o | output | CNT_W | First-parity period total |
| b2_total_o | output | CNT_W | Second-parity period total |
| fe_total_o | output | CNT_W | Far-end period total |
| sd_o | output | 1 | Signal degrade |
| sf_o | output | 1 | Signal fail |
| irq_o | output | 1 | Period interrupt |

## Verification
The assertions assume that the threshold inputs hold steady across the cycle after a period end, and that a parity strobe never falls on a frame-start byte. The stimulus changes thresholds only between frames, well away from any period end. It places the parity bytes at fixed offsets inside each frame. Idle cycles carry random strobes and data with `valid_i` low to test R11. Sync drops fall mid-frame.

// File: rtl/bipm_pkg.sv
package bipm_pkg;
  localparam int unsigned NUM_PAR = 2;
  localparam int unsigned NUM_SUM = 3;

  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + 4'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/bipm_parity.sv
module bipm_parity (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic [7:0] data_i,
  input  logic       incl_i,
  input  logic       pos_i,
  input  logic       sync_ok_i,
  output logic       err_vld_o,
  output logic [3:0] err_cnt_o
);
  import bipm_pkg::*;

  logic [7:0] acc_q, ref_q;
  logic       seen_q, ref_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      ref_q     <= '0;
      seen_q    <= 1'b0;
      ref_ok_q  <= 1'b0;
      err_vld_o <= 1'b0;
      err_cnt_o <= '0;
    end else begin
      err_vld_o <= 1'b0;
      if (valid_i) begin
        // compare uses the reference of the previous frame
        if (pos_i && ref_ok_q) begin
          err_vld_o <= 1'b1;
          err_cnt_o <= pop8(data_i ^ ref_q);
        end
        if (sof_i) begin
          ref_q    <= acc_q;
          acc_q    <= incl_i ? data_i : 8'h00;
          ref_ok_q <= seen_q && sync_ok_i;
          seen_q   <= sync_ok_i;
        end else if (incl_i) begin
          acc_q <= acc_q ^ data_i;
        end
      end
      if (!sync_ok_i) begin
        seen_q   <= 1'b0;
        ref_ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bipm_accum.sv
module bipm_accum #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  input  logic          end_i,
  output logic [W-1:0]  sum_o,
  output logic [W-1:0]  total_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide;

  always_comb begin
    wide  = {1'b0, acc_q} + (W+1)'(inc_i);
    sum_o = wide[W] ? {W{1'b1}} : wide[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      total_o <= '0;
    end else if (end_i) begin
      total_o <= sum_o;
      acc_q   <= '0;
    end else begin
      acc_q <= sum_o;
    end
  end
endmodule

// File: rtl/bipm_period.sv
module bipm_period #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             end_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + 1'b1;
  assign end_o = tick_i && (nxt >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= end_o ? '0 : nxt[PER_W-1:0];
  end
endmodule

// File: rtl/bip_err_monitor.sv
module bip_err_monitor #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PER_W = 16,
  parameter int unsigned FE_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             sof_i,
  input  logic             b1_pos_i,
  input  logic             b2_pos_i,
  input  logic             b2_en_i,
  input  logic             sync_ok_i,
  input  logic             fe_vld_i,
  input  logic [FE_W-1:0]  fe_err_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] sd_thresh_i,
  input  logic [CNT_W-1:0] sf_thresh_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] b1_total_o,
  output logic [CNT_W-1:0] b2_total_o,
  output logic [CNT_W-1:0] fe_total_o,
  output logic             sd_o,
  output logic             sf_o,
  output logic             irq_o
);
  import bipm_pkg::*;

  localparam int unsigned IW = (FE_W > 4) ? FE_W : 4;

  logic [NUM_PAR-1:0] par_incl, par_pos, par_vld;
  logic [3:0]         par_cnt [NUM_PAR];
  logic [IW-1:0]      inc     [NUM_SUM];
  logic [CNT_W-1:0]   sum     [NUM_SUM];
  logic [CNT_W-1:0]   tot     [NUM_SUM];
  logic               period_end;

  assign par_incl = {b2_en_i, 1'b1};
  assign par_pos  = {b2_pos_i, b1_pos_i};

  for (genvar g = 0; g < NUM_PAR; g++) begin : g_par
    bipm_parity u_par (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (valid_i),
      .sof_i     (sof_i),
      .data_i    (data_i),
      .incl_i    (par_incl[g]),
      .pos_i     (par_pos[g]),
      .sync_ok_i (sync_ok_i),
      .err_vld_o (par_vld[g]),
      .err_cnt_o (par_cnt[g])
    );
  end

  always_comb begin
    for (int k = 0; k < NUM_PAR; k++) inc[k] = par_vld[k] ? IW'(par_cnt[k]) : '0;
    inc[NUM_SUM-1] = fe_vld_i ? IW'(fe_err_i) : '0;
  end

  bipm_period #(.PER_W(PER_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (valid_i && sof_i),
    .period_i (period_i),
    .end_o    (period_end)
  );

  for (genvar g = 0; g < NUM_SUM; g++) begin : g_acc
    bipm_accum #(.W(CNT_W), .IW(IW)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[g]),
      .end_i   (period_end),
      .sum_o   (sum[g]),
      .total_o (tot[g])
    );
  end

  assign b1_total_o = tot[0];
  assign b2_total_o = tot[1];
  assign fe_total_o = tot[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o  <= 1'b0;
      sf_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (period_end) begin
        sd_o <= sum[1] > sd_thresh_i;
        sf_o <= sum[1] > sf_thresh_i;
      end
      if (period_end && irq_en_i) irq_o <= 1'b1;
      else if (irq_clr_i)         irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bip_err_monitor_chk.sv
module bip_err_monitor_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             period_end_i,
  input logic [CNT_W-1:0] sd_thresh_i,
  input logic [CNT_W-1:0] sf_thresh_i,
  input logic             irq_en_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] b1_total_i,
  input logic [CNT_W-1:0] b2_total_i,
  input logic [CNT_W-1:0] fe_total_i,
  input logic             sd_i,
  input logic             sf_i,
  input logic             irq_i
);
  AST_TOTALS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> ($stable(b1_total_i) && $stable(b2_total_i) && $stable(fe_total_i))); // R5
  AST_SD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> $stable(sd_i)); // R8
  AST_SD_JUDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> (sd_i == (b2_total_i > $past(sd_thresh_i)))); // R8
  AST_SF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> $stable(sf_i)); // R9
  AST_SF_JUDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> (sf_i == (b2_total_i > $past(sf_thresh_i)))); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !irq_clr_i) |=> irq_i); // R10
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(period_end_i && irq_en_i)) |=> !irq_i); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(period_end_i && irq_en_i)); // R10
endmodule

bind bip_err_monitor bip_err_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .period_end_i (period_end),
  .sd_thresh_i  (sd_thresh_i),
  .sf_thresh_i  (sf_thresh_i),
  .irq_en_i     (irq_en_i),
  .irq_clr_i    (irq_clr_i),
  .b1_total_i   (b1_total_o),
  .b2_total_i   (b2_total_o),
  .fe_total_i   (fe_total_o),
  .sd_i         (sd_o),
  .sf_i         (sf_o),
  .irq_i        (irq_o)
);

// File: tb/bip_err_monitor_bench.sv
module bip_err_monitor_bench;
  localparam int CW = 8, PW = 16, FW = 4, FL = 24, MAXV = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, sof = 0, p1 = 0, p2 = 0, be = 0, sync = 1, fe_vld = 0;
  logic [7:0] data = 0;
  logic [FW-1:0] fe_err = 0;
  logic [PW-1:0] period = 4;
  logic [CW-1:0] sd_th = 5, sf_th = 30;
  logic irq_en = 1, irq_clr = 0;
  logic [CW-1:0] b1_tot, b2_tot, fe_tot;
  logic sd, sf, irq;

  always #4 clk = ~clk;

  bip_err_monitor #(.CNT_W(CW), .PER_W(PW), .FE_W(FW)) u_bip_err_monitor (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data), .sof_i(sof),
    .b1_pos_i(p1), .b2_pos_i(p2), .b2_en_i(be), .sync_ok_i(sync),
    .fe_vld_i(fe_vld), .fe_err_i(fe_err), .period_i(period),
    .sd_thresh_i(sd_th), .sf_thresh_i(sf_th), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .b1_total_o(b1_tot), .b2_total_o(b2_tot), .fe_total_o(fe_tot),
    .sd_o(sd), .sf_o(sf), .irq_o(irq));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, cmp_on = 0;
  string phase = "R1";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_sum[3], m_tot[3], m_fcnt, m_pc[2];
  bit [7:0] m_ref[2], m_acc[2];
  bit m_seen[2], m_ok[2], m_pv[2], m_sd, m_sf, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_sum[k]) begin m_sum[k] = 0; m_tot[k] = 0; end
      for (int p = 0; p < 2; p++) begin
        m_ref[p] = 0; m_acc[p] = 0; m_seen[p] = 0; m_ok[p] = 0; m_pv[p] = 0; m_pc[p] = 0;
      end
      m_fcnt = 0; m_sd = 0; m_sf = 0; m_irq = 0;
    end else begin
      int inc[3];
      bit pe;
      inc[0] = m_pv[0] ? m_pc[0] : 0;
      inc[1] = m_pv[1] ? m_pc[1] : 0;
      inc[2] = fe_vld ? int'(fe_err) : 0;
      pe = valid && sof && (m_fcnt + 1 >= int'(period));
      for (int k = 0; k < 3; k++) begin
        int s;
        s = m_sum[k] + inc[k];
        if (s > MAXV) s = MAXV;
        if (pe) begin m_tot[k] = s; m_sum[k] = 0; end
        else m_sum[k] = s;
      end
      if (pe) begin
        m_sd = m_tot[1] > int'(sd_th);
        m_sf = m_tot[1] > int'(sf_th);
      end
      if (pe && irq_en) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (valid && sof) m_fcnt = pe ? 0 : m_fcnt + 1;
      for (int p = 0; p < 2; p++) begin
        bit inb, psb;
        inb = (p == 0) ? 1'b1 : be;
        psb = (p == 0) ? p1 : p2;
        m_pv[p] = 0;
        if (valid) begin
          if (psb && m_ok[p]) begin m_pv[p] = 1; m_pc[p] = $countones(data ^ m_ref[p]); end
          if (sof) begin
            m_ref[p] = m_acc[p]; m_acc[p] = inb ? data : 8'h00;
            m_ok[p] = m_seen[p] && sync; m_seen[p] = sync;
          end else if (inb) m_acc[p] = m_acc[p] ^ data;
        end
        if (!sync) begin m_seen[p] = 0; m_ok[p] = 0; end
      end
    end
  end

  always @(negedge clk) if (rst_n && cmp_on) begin
    chk("R2 b1_total", b1_tot, m_tot[0]);
    chk("R3 b2_total", b2_tot, m_tot[1]);
    chk("R6 fe_total", fe_tot, m_tot[2]);
    chk("R8 sd", sd, m_sd);
    chk("R9 sf", sf, m_sf);
    chk("R10 irq", irq, m_irq);
  end

  // stimulus-side true parities
  bit [7:0] g_acc1 = 0, g_acc2 = 0, g_ref1 = 0, g_ref2 = 0;

  task automatic idle();
    @(negedge clk);
    valid = 0; fe_vld = 0;
    data = 8'($urandom); sof = 1'($urandom); p1 = 1'($urandom);
    p2 = 1'($urandom); be = 1'($urandom); // R11: junk with valid low
  endtask

  task automatic frame(int e1, int e2, int fev, bit gaps, int drop_at);
    for (int i = 0; i < FL; i++) begin
      bit [7:0] d;
      if (gaps && ($urandom % 4 == 0)) idle();
      @(negedge clk);
      d = 8'($urandom);
      if (i == 0) begin g_ref1 = g_acc1; g_ref2 = g_acc2; g_acc1 = 0; g_acc2 = 0; end
      if (i == 3) d = g_ref1 ^ 8'((1 << e1) - 1);
      if (i == 7) d = g_ref2 ^ 8'((1 << e2) - 1);
      g_acc1 = g_acc1 ^ d;
      if (i >= 5) g_acc2 = g_acc2 ^ d;
      valid = 1; data = d; sof = (i == 0); p1 = (i == 3); p2 = (i == 7); be = (i >= 5);
      fe_vld = (i == 1) && (fev > 0); fe_err = FW'(fev);
      sync = (i != drop_at);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    valid = 0; fe_vld = 0; irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("R1 b1_total reset", b1_tot, 0);
    chk("R1 b2_total reset", b2_tot, 0);
    chk("R1 fe_total reset", fe_tot, 0);
    chk("R1 flags reset", {sd, sf, irq}, 0);
    rst_n = 1; cmp_on = 1;

    phase = "R2 R3 R5";
    for (int i = 0; i < 12; i++) frame(i % 3, (i * 5) % 9, 0, 1, -1);

    phase = "R10";
    pulse_clr();
    irq_en = 0;
    for (int i = 0; i < 5; i++) frame(1, 2, 0, 0, -1);
    chk("R10 irq stays low with enable off", irq, 0);
    irq_en = 1;
    frame(0, 0, 0, 0, -1);

    phase = "R4";
    frame(2, 3, 0, 1, 10);
    for (int i = 0; i < 6; i++) frame(4, 5, 0, 1, (i == 2) ? 5 : -1);

    phase = "R6";
    for (int i = 0; i < 8; i++) frame(0, 1, 3 + i, 1, -1);

    phase = "R8 R9";
    sd_th = 0; sf_th = 40;
    for (int i = 0; i < 8; i++) frame(0, 0, 0, 0, -1);
    for (int i = 0; i < 8; i++) frame(1, 8, 0, 0, -1);
    sd_th = 20; sf_th = 10;
    for (int i = 0; i < 8; i++) frame(1, 4, 0, 0, -1);

    phase = "R7";
    period = 40; sd_th = 100; sf_th = 200;
    for (int i = 0; i < 45; i++) frame(8, 8, 15, 0, -1);
    pulse_clr();

    phase = "R11 R5";
    period = 0;
    for (int i = 0; i < 10; i++) frame(i % 9, (i + 3) % 9, i % 16, 1, -1);
    period = 1;
    for (int i = 0; i < 4; i++) frame(2, 2, 1, 1, -1);
    repeat (6) idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule